// File: doc/BRIEF.md
# Clock Stop and Power-Down Gate

This block sits between the internal clock sources of a clock generator and its output buffers. It receives a CPU clock, a 66 MHz-class clock, a PCI-class clock (used both for the stoppable PCI copies and for one free-running PCI copy), an IOAPIC clock and a REF clock. It hands out a set of copies of each, gated by three asynchronous active-low controls: CPU stop, PCI stop and power-down. Each clock domain synchronizes the controls it cares about with its own two-flop synchronizer. The gate changes state only while its clock is low, so a stopped output always sits low and no clipped pulse ever reaches a pin.

Power-down overrides both stop inputs and drops the oscillator/VCO enable at once. On leaving power-down, a settle counter running on the REF clock holds every output low for a parameterised number of REF cycles. This models the oscillator start-up time. Only after that count do the domains reopen. Clock generation, output drivers and analog timing belong elsewhere. The controls are plain level pins with no handshake.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n_i` is low every clock output is low and `osc_vco_en_o` follows `pwr_dn_n_i`.
- R2: With `cpu_stop_n_i` low (and power-down inactive), `cpu_o` and `m66_o` stay low while `pci_o`, `pci_free_o`, `apic_o` and `ref_o` keep toggling.
- R3: CPU-stop latency. Let the first rising edge of `cpu_clk_i` after `cpu_stop_n_i` changes be edge 1. Edges 1 and 2 still show the old state on `cpu_o`, and edge 3 onward shows the new one. This puts the effect 2 to 3 CPU cycles after the change, for both stop and restart.
- R4: With `pci_stop_n_i` low, all `pci_o` copies stay low while `pci_free_o`, `cpu_o`, `apic_o` and `ref_o` keep toggling. The same 2-edge-pass / 3rd-edge-effect latency applies, counted on `pci_clk_i`.
- R5: With `pwr_dn_n_i` low, every clock output is low within 5 REF cycles plus 3 cycles of its own clock, whatever the stop inputs are.
- R6: After `pwr_dn_n_i` returns high, all outputs stay low for at least `SETTLE_CYC` REF cycles and then run, subject to the stop inputs.
- R7: No shortened pulse. Every high phase of a gated output lasts exactly one full high phase of its source clock, and every low phase lasts at least one full low phase.
- R8: `pci_free_o`, `apic_o` and `ref_o` ignore both stop inputs.
- R9: `osc_vco_en_o` equals `pwr_dn_n_i` with no clock delay: low means oscillator and VCO off.
- R10: All copies of one clock group (the bits of `cpu_o`, `m66_o`, `pci_o`, `apic_o`, `ref_o`) are identical at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Internal CPU clock |
| m66_clk_i | input | 1 | Internal 66 MHz-class clock |
| pci_clk_i | input | 1 | Internal PCI-class clock |
| apic_clk_i | input | 1 | Internal IOAPIC clock |
| ref_clk_i | input | 1 | Internal REF clock, also times the settle count |
| cpu_stop_n_i | input | 1 | Active-low CPU-group stop, asynchronous |
| pci_stop_n_i | input | 1 | Active-low PCI-group stop, asynchronous |
| pwr_dn_n_i | input | 1 | Active-low power-down, asynchronous |
| cpu_o | output | N_CPU | Gated CPU clock copies |
| m66_o | output | N_M66 | Gated 66 MHz-class copies |
| pci_o | output | N_PCI | Gated PCI copies |
| pci_free_o | output | 1 | Free-running PCI copy |
| apic_o | output | N_APIC | IOAPIC copies |
| ref_o | output | N_REF | REF copies |
| osc_vco_en_o | output | 1 | Oscillator and VCO enable |

## Verification
The case that can land in one cycle is the release of power-down together with a change on a stop input. The bench drives `pwr_dn_n_i` high and `cpu_stop_n_i` low in the same instant. It also asserts both stop inputs in one cycle. After the settle window it checks that the CPU and 66 MHz groups stay low while the PCI, free PCI, IOAPIC and REF groups resume. In the double-stop case only the free-running copies may toggle. A pulse-width monitor on the gated outputs runs through every scenario. It flags any high phase that differs from the source half period and any low phase shorter than it.

// File: rtl/clk_stop_gate_pkg.sv
`timescale 1ns/1ps
package clk_stop_gate_pkg;
  // domain slots used by the top-level generate loop
  localparam int DOM_CPU  = 0;
  localparam int DOM_M66  = 1;
  localparam int DOM_PCI  = 2;
  localparam int DOM_PCIF = 3;
  localparam int DOM_APIC = 4;
  localparam int DOM_REF  = 5;
  localparam int N_DOM    = 6;
endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_n_i)
        if (!rst_n_i) ff <= '0;
        else          ff <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_n_i)
        if (!rst_n_i) ff <= '0;
        else          ff <= {ff[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/cg_settle.sv
`timescale 1ns/1ps
module cg_settle #(
  parameter int SETTLE_CYC  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_n_i,
  input  logic pwr_dn_n_i,
  output logic ready_o
);
  localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE_CYC);

  logic          pd_s;
  logic [CW-1:0] cnt;

  cg_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
    .clk_i(ref_clk_i), .rst_n_i(rst_n_i), .d_i(pwr_dn_n_i), .q_o(pd_s));

  always_ff @(posedge ref_clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt     <= '0;
      ready_o <= 1'b0;
    end else if (!pd_s) begin
      cnt     <= '0;
      ready_o <= 1'b0;
    end else begin
      if (cnt != CMAX) cnt <= cnt + 1'b1;
      ready_o <= (cnt == CMAX);
    end
  end

  // R5: a synchronized power-down drops ready on the next REF edge
  assert_pd_drops_ready_R5: assert property (@(posedge ref_clk_i) disable iff (!rst_n_i)
    !pd_s |=> !ready_o);
  // R6: ready only rises while power-down has been released for more than one edge
  assert_ready_after_release_R6: assert property (@(posedge ref_clk_i) disable iff (!rst_n_i)
    $rose(ready_o) |-> (pd_s && $past(pd_s)));
endmodule

// File: rtl/cg_domain.sv
`timescale 1ns/1ps
module cg_domain #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic stop_n_i,
  input  logic ready_i,
  output logic gclk_o
);
  logic stop_s, rdy_s, want, gate_en;

  cg_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(stop_n_i), .q_o(stop_s));
  cg_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(ready_i), .q_o(rdy_s));

  assign want = stop_s & rdy_s;

  // gate register updates on the falling edge: output only changes while clk is low
  always_ff @(negedge clk_i or negedge rst_n_i)
    if (!rst_n_i) gate_en <= 1'b0;
    else          gate_en <= want;

  assign gclk_o = clk_i & gate_en;

  // R3: a synchronized stop closes the gate before the next rising edge
  assert_stop_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(want) |=> !gate_en);
  // R3: a synchronized restart opens the gate before the next rising edge
  assert_start_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(want) |=> gate_en);
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int N_CPU       = 6,
  parameter int N_M66       = 2,
  parameter int N_PCI       = 5,
  parameter int N_APIC      = 3,
  parameter int N_REF       = 2,
  parameter int SETTLE_CYC  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n_i,
  input  logic              cpu_clk_i,
  input  logic              m66_clk_i,
  input  logic              pci_clk_i,
  input  logic              apic_clk_i,
  input  logic              ref_clk_i,
  input  logic              cpu_stop_n_i,
  input  logic              pci_stop_n_i,
  input  logic              pwr_dn_n_i,
  output logic [N_CPU-1:0]  cpu_o,
  output logic [N_M66-1:0]  m66_o,
  output logic [N_PCI-1:0]  pci_o,
  output logic              pci_free_o,
  output logic [N_APIC-1:0] apic_o,
  output logic [N_REF-1:0]  ref_o,
  output logic              osc_vco_en_o
);
  logic             ready;
  logic [N_DOM-1:0] dom_clk, dom_stop_n, dom_gclk;

  cg_settle #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_settle (
    .ref_clk_i(ref_clk_i), .rst_n_i(rst_n_i), .pwr_dn_n_i(pwr_dn_n_i), .ready_o(ready));

  always_comb begin
    dom_clk              = '0;
    dom_stop_n           = '1;
    dom_clk[DOM_CPU]     = cpu_clk_i;
    dom_clk[DOM_M66]     = m66_clk_i;
    dom_clk[DOM_PCI]     = pci_clk_i;
    dom_clk[DOM_PCIF]    = pci_clk_i;
    dom_clk[DOM_APIC]    = apic_clk_i;
    dom_clk[DOM_REF]     = ref_clk_i;
    dom_stop_n[DOM_CPU]  = cpu_stop_n_i;
    dom_stop_n[DOM_M66]  = cpu_stop_n_i;
    dom_stop_n[DOM_PCI]  = pci_stop_n_i;
  end

  generate
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      cg_domain #(.SYNC_STAGES(SYNC_STAGES)) u_dom (
        .clk_i(dom_clk[d]), .rst_n_i(rst_n_i), .stop_n_i(dom_stop_n[d]),
        .ready_i(ready), .gclk_o(dom_gclk[d]));
    end
  endgenerate

  assign cpu_o        = {N_CPU{dom_gclk[DOM_CPU]}};
  assign m66_o        = {N_M66{dom_gclk[DOM_M66]}};
  assign pci_o        = {N_PCI{dom_gclk[DOM_PCI]}};
  assign pci_free_o   = dom_gclk[DOM_PCIF];
  assign apic_o       = {N_APIC{dom_gclk[DOM_APIC]}};
  assign ref_o        = {N_REF{dom_gclk[DOM_REF]}};
  assign osc_vco_en_o = pwr_dn_n_i;
endmodule

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;
  localparam int SETTLE = 16;
  localparam real REF_P = 70.0;

  logic rst_n = 0, cpu_clk = 0, m66_clk = 0, pci_clk = 0, apic_clk = 0, ref_clk = 0;
  logic cpu_stop_n = 1, pci_stop_n = 1, pd_n = 1;
  logic [5:0] cpu_o; logic [1:0] m66_o; logic [4:0] pci_o;
  logic pci_free_o; logic [2:0] apic_o; logic [1:0] ref_o; logic osc_en;

  int n_chk = 0, n_fail = 0;
  int c_cpu = 0, c_m66 = 0, c_pci = 0, c_pcif = 0, c_apic = 0, c_ref = 0;
  int glitches = 0;
  realtime tr_cpu = 0, tf_cpu = -100, tr_m66 = 0, tf_m66 = -100, tr_pci = 0, tf_pci = -100;

  clk_stop_gate #(.SETTLE_CYC(SETTLE)) u_dut (
    .rst_n_i(rst_n), .cpu_clk_i(cpu_clk), .m66_clk_i(m66_clk), .pci_clk_i(pci_clk),
    .apic_clk_i(apic_clk), .ref_clk_i(ref_clk), .cpu_stop_n_i(cpu_stop_n),
    .pci_stop_n_i(pci_stop_n), .pwr_dn_n_i(pd_n), .cpu_o(cpu_o), .m66_o(m66_o),
    .pci_o(pci_o), .pci_free_o(pci_free_o), .apic_o(apic_o), .ref_o(ref_o),
    .osc_vco_en_o(osc_en));

  always #2  cpu_clk  = ~cpu_clk;   // 250 MHz
  always #4  m66_clk  = ~m66_clk;
  always #8  pci_clk  = ~pci_clk;
  always #32 apic_clk = ~apic_clk;
  always #35 ref_clk  = ~ref_clk;

  always @(posedge cpu_o[0])   c_cpu++;
  always @(posedge m66_o[0])   c_m66++;
  always @(posedge pci_o[0])   c_pci++;
  always @(posedge pci_free_o) c_pcif++;
  always @(posedge apic_o[0])  c_apic++;
  always @(posedge ref_o[0])   c_ref++;

  // R7 pulse-width monitors on gated outputs
  always @(posedge cpu_o[0]) begin if ($realtime - tf_cpu < 1.99) glitches++; tr_cpu = $realtime; end
  always @(negedge cpu_o[0]) begin if ($realtime - tr_cpu < 1.99 || $realtime - tr_cpu > 2.01) glitches++; tf_cpu = $realtime; end
  always @(posedge m66_o[0]) begin if ($realtime - tf_m66 < 3.99) glitches++; tr_m66 = $realtime; end
  always @(negedge m66_o[0]) begin if ($realtime - tr_m66 < 3.99 || $realtime - tr_m66 > 4.01) glitches++; tf_m66 = $realtime; end
  always @(posedge pci_o[0]) begin if ($realtime - tf_pci < 7.99) glitches++; tr_pci = $realtime; end
  always @(negedge pci_o[0]) begin if ($realtime - tr_pci < 7.99 || $realtime - tr_pci > 8.01) glitches++; tf_pci = $realtime; end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // edge counts over a window: returns per-group deltas
  task automatic window(input real ns, output int d_cpu, output int d_m66, output int d_pci,
                        output int d_pcif, output int d_apic, output int d_ref);
    int b0, b1, b2, b3, b4, b5;
    b0 = c_cpu; b1 = c_m66; b2 = c_pci; b3 = c_pcif; b4 = c_apic; b5 = c_ref;
    #(ns);
    d_cpu = c_cpu - b0; d_m66 = c_m66 - b1; d_pci = c_pci - b2;
    d_pcif = c_pcif - b3; d_apic = c_apic - b4; d_ref = c_ref - b5;
  endtask

  task automatic t_reset();
    int a, b, c, d, e, f;
    window(300.0, a, b, c, d, e, f);
    chk(a + b + c + d + e + f == 0, "R1", "edges during reset", a + b + c + d + e + f, 0);
    chk(osc_en == 1'b1, "R1", "osc enable in reset", osc_en, 1);
  endtask

  task automatic t_settle(input string tag);
    int a, b, c, d, e, f;
    window((SETTLE - 1) * REF_P, a, b, c, d, e, f);
    chk(a + b + c + d + e + f == 0, tag, "edges inside settle window", a + b + c + d + e + f, 0);
    #(12 * REF_P);
    window(600.0, a, b, c, d, e, f);
    chk(a > 100 && c > 20 && d > 20 && f > 5, tag, "cpu edges after settle", a, 150);
    chk(cpu_o == {6{cpu_o[0]}} && pci_o == {5{pci_o[0]}} && apic_o == {3{apic_o[0]}},
        "R10", "copies identical", int'(cpu_o), 0);
  endtask

  // which: 0 = CPU group on cpu_clk, 1 = PCI group on pci_clk
  task automatic t_latency(input int which, input bit new_lvl, input string tag);
    logic s;
    if (which == 0) @(posedge cpu_clk); else @(posedge pci_clk);
    #1;
    if (which == 0) cpu_stop_n = new_lvl; else pci_stop_n = new_lvl;
    for (int k = 1; k <= 4; k++) begin
      if (which == 0) @(posedge cpu_clk); else @(posedge pci_clk);
      #1;
      s = (which == 0) ? cpu_o[0] : pci_o[0];
      chk(s == ((k <= 2) ? ~new_lvl : new_lvl), tag, $sformatf("output at edge %0d", k),
          s, (k <= 2) ? ~new_lvl : new_lvl);
    end
  endtask

  task automatic t_cpu_stop();
    int a, b, c, d, e, f;
    t_latency(0, 1'b0, "R3 stop");
    #40;
    window(1000.0, a, b, c, d, e, f);
    chk(a == 0 && b == 0, "R2", "cpu+m66 edges while stopped", a + b, 0);
    chk(c >= 60 && d >= 60, "R2", "pci edges while cpu stopped", c, 62);
    chk(e >= 14 && f >= 13, "R8", "apic/ref run during cpu stop", e + f, 28);
    chk(cpu_o == 6'h0 && m66_o == 2'h0, "R2", "stopped level low", int'(cpu_o), 0);
    t_latency(0, 1'b1, "R3 restart");
  endtask

  task automatic t_pci_stop();
    int a, b, c, d, e, f;
    t_latency(1, 1'b0, "R4 stop");
    #40;
    window(1000.0, a, b, c, d, e, f);
    chk(c == 0 && pci_o == 5'h0, "R4", "pci edges while stopped", c, 0);
    chk(d >= 60, "R8", "free pci runs during pci stop", d, 62);
    chk(a >= 240 && e >= 14 && f >= 13, "R4", "cpu edges during pci stop", a, 250);
    t_latency(1, 1'b1, "R4 restart");
  endtask

  task automatic t_both_stops();
    int a, b, c, d, e, f;
    @(posedge cpu_clk); #1;
    cpu_stop_n = 0; pci_stop_n = 0;
    #100;
    window(1000.0, a, b, c, d, e, f);
    chk(a + b + c == 0, "R2", "all stoppable groups low", a + b + c, 0);
    chk(d >= 60 && e >= 14 && f >= 13, "R8", "free clocks run, both stops", d, 62);
    cpu_stop_n = 1; pci_stop_n = 1;
    #100;
  endtask

  task automatic t_pwrdn();
    int a, b, c, d, e, f;
    @(posedge cpu_clk); #1;
    pd_n = 0;
    #1;
    chk(osc_en == 1'b0, "R9", "osc enable follows power-down", osc_en, 0);
    #(5 * REF_P + 40);
    cpu_stop_n = 0; pci_stop_n = 1;
    window(800.0, a, b, c, d, e, f);
    chk(a + b + c + d + e + f == 0, "R5", "edges in power-down", a + b + c + d + e + f, 0);
    chk({cpu_o, m66_o, pci_o, pci_free_o, apic_o, ref_o} == '0, "R5", "levels in power-down", 1, 0);
    cpu_stop_n = 1;
    #(200);
    // same instant: leave power-down and assert CPU stop
    @(posedge cpu_clk); #1;
    pd_n = 1; cpu_stop_n = 0;
    #1;
    chk(osc_en == 1'b1, "R9", "osc enable after release", osc_en, 1);
    window((SETTLE - 1) * REF_P, a, b, c, d, e, f);
    chk(a + b + c + d + e + f == 0, "R6", "edges before settle expiry", a + b + c + d + e + f, 0);
    #(12 * REF_P);
    window(800.0, a, b, c, d, e, f);
    chk(a == 0 && b == 0, "R2", "cpu held by stop after power-up", a + b, 0);
    chk(c >= 45 && d >= 45 && e >= 10 && f >= 10, "R6", "others resume after settle", c, 50);
    cpu_stop_n = 1;
    #100;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    rst_n = 1;
    t_settle("R6 after reset");
    t_cpu_stop();
    t_pci_stop();
    t_both_stops();
    t_pwrdn();
    chk(glitches == 0, "R7", "shortened pulses seen", glitches, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule